// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out the operand address for one memory-reference instruction in a 15-bit byte address space split into four 8K pages. It covers two base modes. In relative mode a short signed displacement is added to the address of the current instruction. In absolute mode the address field is used directly. On top of the base mode it can apply indexing, with an optional pre-increment or pre-decrement of the index register, and it can apply indirection, where a two-byte pointer is fetched from memory. Opcode decode and the memory itself sit outside the block.

A controller pulses `start` with the instruction's fields. The block then runs its state machine. IDLE accepts the request and moves to BASE. BASE forms the direct address. From BASE the machine goes to FINISH when there is no indirection, or to PTR_HI when there is. PTR_HI fetches the pointer's upper byte and moves to PTR_LO once memory answers. PTR_LO fetches the lower byte and moves to POST once memory answers. POST adds the index to the pointer if indexing is selected, then moves to FINISH. FINISH raises `done` for one cycle, presents the result and the updated index, and returns to IDLE. Each pointer byte is read through a request/valid handshake that can absorb any number of wait cycles.

Top module: `opnd_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `ptr_req` and `idx_we` are low and `ea` is zero.
- R2: When `abs_mode`=0 (relative), the displacement is `addr_field[6:0]` read as two's complement (-64..+63). The target keeps `cur_addr[14:13]` and sets its low 13 bits to `cur_addr[12:0]` plus the displacement, modulo 8192. Bits `addr_field[14:7]` are ignored.
- R3: When `abs_mode`=1, `indirect`=0 and `idx_op`=00, `ea` equals `addr_field`.
- R4: `idx_op` encodes 00 = no indexing, 01 = index unchanged, 10 = pre-increment, 11 = pre-decrement. The modified value wraps modulo 256 and is the value added. In absolute mode with a non-zero `idx_op`, it appears on `idx_new` with `idx_we`=1 in the `done` cycle.
- R5: The indexed sum adds the 8-bit modified index as an unsigned number to the low 13 bits of the base, modulo 8192, and keeps the base's page bits [14:13].
- R6: In relative mode, `idx_op` has no effect on `ea`, and `idx_we` stays low.
- R7: When `indirect`=1, the pointer's upper byte is read at the direct address A. The lower byte is read at A+1, taken within A's page. The pointer is big-endian and its low 15 bits form the result.
- R8: With both indexing and indirection, the index is added to the fetched pointer (within the pointer's page) and never to the address field.
- R9: `ptr_req` stays high with `ptr_addr` unchanged in every cycle until a cycle with `rd_valid`=1 completes the byte. Any number of wait cycles is accepted.
- R10: A direct request accepted at a clock edge shows `done`=1 after the second edge. `done` lasts one cycle, and `busy` is low in the cycle after `done`.
- R11: `start` is ignored while `busy` is high. The running operation's result is unchanged, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| abs_mode | input | 1 | 1 = absolute, 0 = relative |
| indirect | input | 1 | 1 = fetch a pointer at the direct address |
| idx_op | input | 2 | Index operation (see R4) |
| cur_addr | input | 15 | Address of the current instruction |
| addr_field | input | 15 | Instruction address field (displacement in bits 6:0 for relative) |
| idx_in | input | 8 | Index register value |
| rd_valid | input | 1 | Memory byte valid |
| rd_data | input | 8 | Memory byte |
| ptr_req | output | 1 | Pointer byte read request |
| ptr_addr | output | 15 | Pointer byte address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid, one cycle |
| ea | output | 15 | Effective address |
| idx_new | output | 8 | Updated index value |
| idx_we | output | 1 | Write strobe for `idx_new` |

## Verification
The bench builds the block with its default parameters: a 15-bit address, a 13-bit page offset, a 7-bit displacement and an 8-bit index. With these values, every page boundary is only a few bytes from a small address, so the vectors can place relative targets and indexed sums on both sides of the 8K wrap. The same values let the index pass through 0xFF and 0x00 in one step, and let a pointer's second byte fall on the next page's start, where it must wrap back. Wait states on the memory side are varied, and a stray `start` is injected in the middle of a fetch.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE,
        ST_PTR_HI,
        ST_PTR_LO,
        ST_POST,
        ST_FINISH
    } eag_state_e;

    typedef enum logic [1:0] {
        IX_NONE  = 2'b00,
        IX_PLAIN = 2'b01,
        IX_INC   = 2'b10,
        IX_DEC   = 2'b11
    } ix_op_e;
endpackage

// File: rtl/eag_page_add.sv
// Adds an offset to the low part of an address; the page bits pass unchanged.
module eag_page_add #(
    parameter int ADDR_W     = 15,
    parameter int OFS_W      = 13,
    parameter int OFF_W      = 7,
    parameter bit SIGNED_OFF = 1'b1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] sum
);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int EXT_W  = OFS_W - OFF_W;

    logic [OFS_W-1:0] off_ext;
    logic [OFS_W-1:0] low_sum;

    generate
        if (SIGNED_OFF) begin : g_sext
            assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        end else begin : g_zext
            assign off_ext = {{EXT_W{1'b0}}, off};
        end
    endgenerate

    assign low_sum = base[OFS_W-1:0] + off_ext;
    assign sum     = {base[ADDR_W-1 -: PAGE_W], low_sum};
endmodule

// File: rtl/eag_index_prep.sv
// Applies the optional pre-increment / pre-decrement to the index value.
module eag_index_prep
    import eag_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [1:0]       op_raw,
    input  logic [IDX_W-1:0] val,
    output logic [IDX_W-1:0] val_mod,
    output logic             active
);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    ix_op_e op;
    assign op     = ix_op_e'(op_raw);
    assign active = (op != IX_NONE);

    always_comb begin
        unique case (op)
            IX_INC:  val_mod = val + ONE;
            IX_DEC:  val_mod = val - ONE;
            default: val_mod = val;
        endcase
    end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
    import eag_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_OFS_W = 13,
    parameter int DISP_W     = 7,
    parameter int IDX_W      = 8,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abs_mode,
    input  logic              indirect,
    input  logic [1:0]        idx_op,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] addr_field,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic              rd_valid,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              ptr_req,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic [IDX_W-1:0]  idx_new,
    output logic              idx_we
);
    localparam int HI_USE_W = ADDR_W - BYTE_W;
    localparam int PAGE_W   = ADDR_W - PAGE_OFS_W;

    eag_state_e st_q, st_d;

    logic              abs_q, ind_q;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] cur_q, fld_q, base_q, ptr_q, ea_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] hi_q;

    logic [IDX_W-1:0]  idx_mod;
    logic              idx_act, idx_use;
    logic [ADDR_W-1:0] rel_sum, idx_base, idx_sum, nxt_addr, dir_addr;

    // Index preparation (R4)
    eag_index_prep #(.IDX_W(IDX_W)) u_prep (
        .op_raw (op_q),
        .val    (idx_q),
        .val_mod(idx_mod),
        .active (idx_act)
    );

    // Indexing only with absolute addressing (R6)
    assign idx_use = abs_q & idx_act;

    // Relative target within the instruction's page (R2)
    eag_page_add #(.ADDR_W(ADDR_W), .OFS_W(PAGE_OFS_W), .OFF_W(DISP_W), .SIGNED_OFF(1'b1)) u_rel (
        .base(cur_q),
        .off (fld_q[DISP_W-1:0]),
        .sum (rel_sum)
    );

    // Indexed sum: on the field before indirection, on the pointer after (R5, R8)
    assign idx_base = (st_q == ST_POST) ? ptr_q : fld_q;

    eag_page_add #(.ADDR_W(ADDR_W), .OFS_W(PAGE_OFS_W), .OFF_W(IDX_W), .SIGNED_OFF(1'b0)) u_idx (
        .base(idx_base),
        .off (idx_mod),
        .sum (idx_sum)
    );

    // Second pointer byte address, wrapped in the page (R7)
    eag_page_add #(.ADDR_W(ADDR_W), .OFS_W(PAGE_OFS_W), .OFF_W(1), .SIGNED_OFF(1'b0)) u_nxt (
        .base(base_q),
        .off (1'b1),
        .sum (nxt_addr)
    );

    always_comb begin
        if (!abs_q)                   dir_addr = rel_sum;
        else if (idx_use && !ind_q)   dir_addr = idx_sum;
        else                          dir_addr = fld_q;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_BASE;
            ST_BASE:   st_d = ind_q ? ST_PTR_HI : ST_FINISH;
            ST_PTR_HI: if (rd_valid) st_d = ST_PTR_LO;
            ST_PTR_LO: if (rd_valid) st_d = ST_POST;
            ST_POST:   st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abs_q  <= 1'b0;
            ind_q  <= 1'b0;
            op_q   <= 2'b00;
            cur_q  <= '0;
            fld_q  <= '0;
            idx_q  <= '0;
            base_q <= '0;
            hi_q   <= '0;
            ptr_q  <= '0;
            ea_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        abs_q <= abs_mode;
                        ind_q <= indirect;
                        op_q  <= idx_op;
                        cur_q <= cur_addr;
                        fld_q <= addr_field;
                        idx_q <= idx_in;
                    end
                end
                ST_BASE: begin
                    if (ind_q) base_q <= dir_addr;
                    else       ea_q   <= dir_addr;
                end
                ST_PTR_HI: if (rd_valid) hi_q <= rd_data;
                ST_PTR_LO: if (rd_valid) ptr_q <= {hi_q[HI_USE_W-1:0], rd_data};
                ST_POST:   ea_q <= idx_use ? idx_sum : ptr_q;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (st_q != ST_IDLE);
        done     = (st_q == ST_FINISH);
        ptr_req  = (st_q == ST_PTR_HI) || (st_q == ST_PTR_LO);
        ptr_addr = (st_q == ST_PTR_LO) ? nxt_addr : base_q;
        idx_we   = done && idx_use;
        ea       = ea_q;
        idx_new  = idx_mod;
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r10_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && !rd_valid) |=> (ptr_req && $stable(ptr_addr)));
    a_r4_we_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |-> done);
    a_r11_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cur_q) && $stable(fld_q) && $stable(op_q) && $stable(idx_q)));
    a_r2_rel_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !abs_q && !ind_q) |-> (ea[ADDR_W-1 -: PAGE_W] == cur_q[ADDR_W-1 -: PAGE_W]));
endmodule

// File: tb/opnd_addr_gen_tb.sv
`timescale 1ns/1ps
module opnd_addr_gen_tb;
    typedef struct packed {
        logic        absm;
        logic        ind;
        logic [1:0]  op;
        logic [14:0] cur;
        logic [14:0] fld;
        logic [7:0]  idx;
        logic [14:0] exp_ea;
        logic [7:0]  exp_idx;
        logic        exp_we;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    // Memory model: byte at A = A[7:0] ^ {0, A[14:8]}
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,2'b00,15'h0100,15'h7F05,8'h33,15'h0105,8'h33,1'b0,4'd2}, // R2 upper field ignored
        '{1'b0,1'b0,2'b00,15'h2010,15'h0040,8'h00,15'h3FD0,8'h00,1'b0,4'd2}, // R2 -64, wrap down
        '{1'b0,1'b0,2'b00,15'h7FF0,15'h003F,8'h00,15'h602F,8'h00,1'b0,4'd2}, // R2 +63, wrap up
        '{1'b0,1'b0,2'b10,15'h0200,15'h0001,8'h05,15'h0201,8'h06,1'b0,4'd6}, // R6
        '{1'b1,1'b0,2'b00,15'h0000,15'h1234,8'h77,15'h1234,8'h77,1'b0,4'd3}, // R3
        '{1'b1,1'b0,2'b01,15'h0000,15'h1F00,8'h05,15'h1F05,8'h05,1'b1,4'd5}, // R5
        '{1'b1,1'b0,2'b10,15'h0000,15'h1F00,8'h05,15'h1F06,8'h06,1'b1,4'd4}, // R4 inc
        '{1'b1,1'b0,2'b11,15'h0000,15'h1000,8'hA6,15'h10A5,8'hA5,1'b1,4'd4}, // R4 dec
        '{1'b1,1'b0,2'b10,15'h0000,15'h4000,8'hFF,15'h4000,8'h00,1'b1,4'd4}, // R4 inc wrap
        '{1'b1,1'b0,2'b11,15'h0000,15'h0010,8'h00,15'h010F,8'hFF,1'b1,4'd4}, // R4 dec wrap
        '{1'b1,1'b0,2'b01,15'h0000,15'h5FF0,8'h20,15'h4010,8'h20,1'b1,4'd5}, // R5 page wrap
        '{1'b1,1'b1,2'b00,15'h0000,15'h0123,8'h00,15'h2225,8'h00,1'b0,4'd7}, // R7
        '{1'b1,1'b1,2'b10,15'h0000,15'h0A10,8'h0F,15'h1A2B,8'h10,1'b1,4'd8}, // R8
        '{1'b0,1'b1,2'b00,15'h3000,15'h007E,8'h00,15'h51D0,8'h00,1'b0,4'd7}, // R7 relative
        '{1'b1,1'b1,2'b00,15'h0000,15'h1FFF,8'h00,15'h6000,8'h00,1'b0,4'd7}  // R7 page end
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abs_mode = 1'b0, indirect = 1'b0;
    logic [1:0]  idx_op = 2'b00;
    logic [14:0] cur_addr = '0, addr_field = '0;
    logic [7:0]  idx_in = '0;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        ptr_req, busy, done, idx_we;
    logic [14:0] ptr_addr, ea;
    logic [7:0]  idx_new;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int mem_wait = 0, wcnt = 0, hold_err = 0, log_n = 0;
    logic [14:0] log_a [4];
    logic        pv_req = 1'b0, pv_val = 1'b0;
    logic [14:0] pv_addr = '0;

    opnd_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abs_mode(abs_mode),
        .indirect(indirect), .idx_op(idx_op), .cur_addr(cur_addr),
        .addr_field(addr_field), .idx_in(idx_in), .rd_valid(rd_valid),
        .rd_data(rd_data), .ptr_req(ptr_req), .ptr_addr(ptr_addr),
        .busy(busy), .done(done), .ea(ea), .idx_new(idx_new), .idx_we(idx_we)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    // Memory responder with wait states and hold monitor (R9)
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_valid = 1'b0; wcnt = 0; pv_req = 1'b0; pv_val = 1'b0;
        end else begin
            if (pv_req && !pv_val && !(ptr_req && ptr_addr == pv_addr)) hold_err++;
            pv_req  = ptr_req;
            pv_addr = ptr_addr;
            if (rd_valid) begin
                rd_valid = 1'b0; wcnt = 0;
            end else if (ptr_req) begin
                if (wcnt >= mem_wait) begin
                    rd_valid = 1'b1;
                    rd_data  = mem_byte(ptr_addr);
                    if (log_n < 4) begin log_a[log_n] = ptr_addr; log_n++; end
                end else wcnt++;
            end
            pv_val = rd_valid;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge where done is seen.
    task automatic run_vec(input vec_t v, output int n);
        abs_mode = v.absm; indirect = v.ind; idx_op = v.op;
        cur_addr = v.cur; addr_field = v.fld; idx_in = v.idx;
        log_n = 0;
        start = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            n++;
        end while (!done && n < 200);
    endtask

    initial begin
        int n;
        string rq;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !ptr_req && !idx_we, "R1", "flags in reset", {busy,done,ptr_req,idx_we}, 0);
        chk(ea == 0, "R1", "ea in reset", ea, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !ptr_req && !idx_we && ea == 0, "R1", "after reset", {busy,done,ptr_req,idx_we}, 0);

        for (int i = 0; i < NV; i++) begin
            mem_wait = i % 3;
            rq = $sformatf("R%0d", VECS[i].req);
            run_vec(VECS[i], n);
            chk(done == 1'b1, rq, $sformatf("done vec %0d", i), done, 1);
            chk(ea == VECS[i].exp_ea, rq, $sformatf("ea vec %0d", i), ea, VECS[i].exp_ea);
            chk(idx_we == VECS[i].exp_we, rq, $sformatf("idx_we vec %0d", i), idx_we, VECS[i].exp_we);
            if (VECS[i].exp_we)
                chk(idx_new == VECS[i].exp_idx, rq, $sformatf("idx_new vec %0d", i), idx_new, VECS[i].exp_idx);
            if (!VECS[i].ind)
                chk(n == 2, "R10", $sformatf("latency vec %0d", i), n, 2);
            @(negedge clk);
            chk(!done && !busy, "R10", $sformatf("release vec %0d", i), {done,busy}, 0);
        end
        chk(hold_err == 0, "R9", "request hold over vectors", hold_err, 0);

        // R7: second byte wraps inside the page
        mem_wait = 0;
        run_vec(VECS[14], n);
        chk(log_n == 2, "R7", "byte count", log_n, 2);
        chk(log_a[0] == 15'h1FFF, "R7", "first byte addr", log_a[0], 15'h1FFF);
        chk(log_a[1] == 15'h0000, "R7", "second byte addr", log_a[1], 15'h0000);
        @(negedge clk);

        // R9 + R11: long waits, stray start during the fetch
        mem_wait = 4;
        hold_err = 0;
        abs_mode = VECS[12].absm; indirect = VECS[12].ind; idx_op = VECS[12].op;
        cur_addr = VECS[12].cur; addr_field = VECS[12].fld; idx_in = VECS[12].idx;
        log_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(ptr_req == 1'b1 && ptr_addr == 15'h0A10, "R9", "waiting request", ptr_addr, 15'h0A10);
        abs_mode = 1'b1; indirect = 1'b0; idx_op = 2'b00; addr_field = 15'h0000; idx_in = 8'h99;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        chk(ea == 15'h1A2B, "R11", "result with stray start", ea, 15'h1A2B);
        chk(idx_new == 8'h10, "R11", "index with stray start", idx_new, 8'h10);
        chk(hold_err == 0, "R9", "request hold with waits", hold_err, 0);
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !done, "R11", "no second operation", {busy,done}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule